// File: doc/BRIEF.md
# Trace Stream Program Counter Rebuilder

This block sits downstream of a processor core's instruction trace port. Each incoming 36-bit record has a 32-bit payload and four flag bits. A branch record's payload is a new program counter, an address record's payload is a load or store address, and a data record's payload is a result value. Only branch records carry the program counter explicitly. The block therefore keeps its own running PC and steps it forward by each retired instruction's length. It emits every input record once, in order, annotated with a record kind, the reconstructed PC and a flag saying whether that PC is trustworthy.

To learn an instruction's length the block asks an external lookup port with the current PC. The answer is either "no information" or the two low opcode bits. It uses that answer to step the PC by 4 bytes or 2 bytes. Tracking is gained from branch records and from interrupt entry, which forces the PC to a fixed vector. Tracking is lost whenever the lookup has no entry. All three interfaces use valid/ready handshaking.

Top module: `trace_pc_rebuild`

## Requirements
- R1: After reset no output is pending, no lookup is requested and the PC is untracked. Records that arrive before the first branch or interrupt entry are emitted with `out_pc_ok` low, and no lookup is made for them.
- R2: Input bit 32 marks a branch record, bit 33 an address record and bit 35 an active interrupt handler. `out_kind` is 2'b01 for a branch, 2'b10 for an address and 2'b00 for data. When bits 32 and 33 are both set, the kind is branch.
- R3: A branch record is emitted with the PC held before it, or untracked if there was none. Afterwards the PC equals the branch payload and is tracked, even if the lookup for the branch itself missed.
- R4: A non-address record with a tracked PC and a lookup hit advances the PC by 4 when the returned opcode bits are 2'b11, and by 2 otherwise.
- R5: An address record is annotated with the current PC but never advances it.
- R6: When bit 35 is 1 and the previous accepted record had it at 0 (0 after reset), the PC is forced to IRQ_VECTOR (default 0x10) and tracked before this record is annotated. A run of records with bit 35 set forces the PC only once.
- R7: A lookup miss emits the record with `out_pc_ok` low. The PC stays untracked, with no further lookups, until a branch record or interrupt entry.
- R8: Exactly one lookup is requested for each record that has a tracked PC. It carries that PC and holds it stable until accepted.
- R9: `in_ready` is low while a lookup is outstanding. A pending output holds every field stable while `out_ready` is low.
- R10: Exactly one output is produced per input, in input order. The payload and all four flag bits are carried unchanged to `out_payload` and `out_flags`.
- R11: `out_pc` is zero whenever `out_pc_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trace record offered |
| in_ready | output | 1 | Trace record accepted this cycle when valid |
| in_rec | input | 36 | Trace record: flags in [35:32], payload in [31:0] |
| lk_req_valid | output | 1 | Length lookup request |
| lk_req_ready | input | 1 | Lookup request accepted |
| lk_req_pc | output | 32 | PC to look up |
| lk_rsp_valid | input | 1 | Lookup answer present |
| lk_rsp_hit | input | 1 | Lookup found an instruction at the PC |
| lk_rsp_opc | input | 2 | Low two opcode bits of that instruction |
| out_valid | output | 1 | Annotated record present |
| out_ready | input | 1 | Downstream accepts the annotated record |
| out_kind | output | 2 | Record kind (R2 encoding) |
| out_flags | output | 4 | Raw flag bits of the record |
| out_payload | output | 32 | Raw payload of the record |
| out_pc | output | 32 | Reconstructed PC, zero when untracked |
| out_pc_ok | output | 1 | Reconstructed PC is trustworthy |

## Verification
A wrong running PC does not show up when it goes bad. It shows up on the next tracked record, as an `out_pc` that differs from the expected walk. It also appears as a lookup request for the wrong address in the cycle after that record is accepted. A stuck tracked/untracked flag appears as an unexpected lookup count or a wrong `out_pc_ok` on the very next record. A stale interrupt-history bit shows as a PC that was forced, or not forced, to the vector on the first record of a handler. A lost or duplicated output is caught when the scoreboard queue runs dry or is left non-empty at the end.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int FLAG_W       = 4;
    localparam int FLAG_BR_OFS  = 0;
    localparam int FLAG_ADR_OFS = 1;
    localparam int FLAG_IRQ_OFS = 3;

    typedef enum logic [1:0] {
        KIND_DATA   = 2'b00,
        KIND_BRANCH = 2'b01,
        KIND_ADDR   = 2'b10
    } trc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_WAIT = 2'b10
    } trc_state_e;

endpackage

// File: rtl/trc_flag_decode.sv
module trc_flag_decode
    import trc_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    localparam int REC_W    = PAYLOAD_W + FLAG_W
) (
    input  logic [REC_W-1:0]     rec,
    output trc_kind_e            kind,
    output logic                 irq,
    output logic                 is_addr,
    output logic                 is_branch,
    output logic [FLAG_W-1:0]    flags,
    output logic [PAYLOAD_W-1:0] payload
);
    always_comb begin
        flags     = rec[REC_W-1:PAYLOAD_W];
        payload   = rec[PAYLOAD_W-1:0];
        irq       = flags[FLAG_IRQ_OFS];
        is_branch = flags[FLAG_BR_OFS];
        is_addr   = flags[FLAG_ADR_OFS];
        // branch wins when both markers are present
        if (is_branch)    kind = KIND_BRANCH;
        else if (is_addr) kind = KIND_ADDR;
        else              kind = KIND_DATA;
    end
endmodule

// File: rtl/trc_pc_step.sv
module trc_pc_step #(
    parameter int         PAYLOAD_W   = 32,
    parameter logic [1:0] FULL_CODE   = 2'b11,
    parameter int         FULL_BYTES  = 4,
    parameter int         SHORT_BYTES = 2
) (
    input  logic [PAYLOAD_W-1:0] pc,
    input  logic [1:0]           opc,
    input  logic                 hold,
    output logic [PAYLOAD_W-1:0] next_pc
);
    localparam logic [PAYLOAD_W-1:0] FULL_INC  = PAYLOAD_W'(FULL_BYTES);
    localparam logic [PAYLOAD_W-1:0] SHORT_INC = PAYLOAD_W'(SHORT_BYTES);

    always_comb begin
        if (hold)                   next_pc = pc;
        else if (opc == FULL_CODE)  next_pc = pc + FULL_INC;
        else                        next_pc = pc + SHORT_INC;
    end
endmodule

// File: rtl/trc_pc_track.sv
module trc_pc_track
    import trc_pkg::*;
#(
    parameter int                   PAYLOAD_W  = 32,
    parameter logic [PAYLOAD_W-1:0] IRQ_VECTOR = 'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  trc_kind_e            dec_kind,
    input  logic                 dec_irq,
    input  logic                 dec_addr,
    input  logic                 dec_branch,
    input  logic [FLAG_W-1:0]    dec_flags,
    input  logic [PAYLOAD_W-1:0] dec_payload,
    input  logic                 slot_free,
    output logic                 lk_req_valid,
    input  logic                 lk_req_ready,
    output logic [PAYLOAD_W-1:0] lk_req_pc,
    input  logic                 lk_rsp_valid,
    input  logic                 lk_rsp_hit,
    input  logic [1:0]           lk_rsp_opc,
    output logic                 emit_valid,
    output trc_kind_e            emit_kind,
    output logic [FLAG_W-1:0]    emit_flags,
    output logic [PAYLOAD_W-1:0] emit_payload,
    output logic [PAYLOAD_W-1:0] emit_pc,
    output logic                 emit_pc_ok
);
    typedef struct packed {
        trc_state_e             st;
        logic [PAYLOAD_W-1:0]   pc;
        logic                   pc_ok;
        logic                   last_irq;
        logic [PAYLOAD_W-1:0]   lk_pc;
        trc_kind_e              p_kind;
        logic [FLAG_W-1:0]      p_flags;
        logic [PAYLOAD_W-1:0]   p_payload;
        logic                   p_addr;
        logic                   p_branch;
    } track_s;

    track_s t_d, t_q;

    logic                 accept;
    logic                 irq_rise;
    logic [PAYLOAD_W-1:0] pc_eff;
    logic                 ok_eff;
    logic [PAYLOAD_W-1:0] step_pc;

    trc_pc_step #(.PAYLOAD_W(PAYLOAD_W)) u_step (
        .pc      (t_q.lk_pc),
        .opc     (lk_rsp_opc),
        .hold    (t_q.p_addr),
        .next_pc (step_pc)
    );

    always_comb begin
        t_d          = t_q;
        in_ready     = (t_q.st == ST_IDLE) && slot_free;
        accept       = in_valid && in_ready;
        irq_rise     = dec_irq && !t_q.last_irq;
        pc_eff       = irq_rise ? IRQ_VECTOR : t_q.pc;
        ok_eff       = irq_rise || t_q.pc_ok;
        lk_req_valid = 1'b0;
        lk_req_pc    = t_q.lk_pc;
        emit_valid   = 1'b0;
        emit_kind    = t_q.p_kind;
        emit_flags   = t_q.p_flags;
        emit_payload = t_q.p_payload;
        emit_pc      = '0;
        emit_pc_ok   = 1'b0;

        unique case (t_q.st)
            ST_IDLE: begin
                if (accept) begin
                    t_d.last_irq = dec_irq;
                    if (ok_eff) begin
                        t_d.st        = ST_REQ;
                        t_d.pc        = pc_eff;
                        t_d.pc_ok     = 1'b1;
                        t_d.lk_pc     = pc_eff;
                        t_d.p_kind    = dec_kind;
                        t_d.p_flags   = dec_flags;
                        t_d.p_payload = dec_payload;
                        t_d.p_addr    = dec_addr;
                        t_d.p_branch  = dec_branch;
                    end else begin
                        emit_valid   = 1'b1;
                        emit_kind    = dec_kind;
                        emit_flags   = dec_flags;
                        emit_payload = dec_payload;
                        if (dec_branch) begin
                            t_d.pc    = dec_payload;
                            t_d.pc_ok = 1'b1;
                        end
                    end
                end
            end
            ST_REQ: begin
                lk_req_valid = 1'b1;
                if (lk_req_ready) t_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (lk_rsp_valid) begin
                    emit_valid = 1'b1;
                    emit_pc    = lk_rsp_hit ? t_q.lk_pc : '0;
                    emit_pc_ok = lk_rsp_hit;
                    t_d.st     = ST_IDLE;
                    if (t_q.p_branch) begin
                        t_d.pc    = t_q.p_payload;
                        t_d.pc_ok = 1'b1;
                    end else if (lk_rsp_hit) begin
                        t_d.pc    = step_pc;
                        t_d.pc_ok = 1'b1;
                    end else begin
                        t_d.pc_ok = 1'b0;
                    end
                end
            end
            default: t_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q          <= '0;
            t_q.st       <= ST_IDLE;
            t_q.p_kind   <= KIND_DATA;
        end else begin
            t_q <= t_d;
        end
    end

    AST_STALL_WHILE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.st != ST_IDLE) |-> !in_ready); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req_valid && !lk_req_ready) |=> (lk_req_valid && $stable(lk_req_pc))); // R8
    AST_IRQ_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && irq_rise) |=> (lk_req_valid && lk_req_pc == IRQ_VECTOR)); // R6
    AST_NO_LOOKUP_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ok_eff) |=> !lk_req_valid); // R7
endmodule

// File: rtl/trc_out_stage.sv
module trc_out_stage
    import trc_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 emit_valid,
    input  trc_kind_e            emit_kind,
    input  logic [FLAG_W-1:0]    emit_flags,
    input  logic [PAYLOAD_W-1:0] emit_payload,
    input  logic [PAYLOAD_W-1:0] emit_pc,
    input  logic                 emit_pc_ok,
    output logic                 slot_free,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [1:0]           out_kind,
    output logic [FLAG_W-1:0]    out_flags,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic [PAYLOAD_W-1:0] out_pc,
    output logic                 out_pc_ok
);
    typedef struct packed {
        logic                 valid;
        trc_kind_e            kind;
        logic [FLAG_W-1:0]    flags;
        logic [PAYLOAD_W-1:0] payload;
        logic [PAYLOAD_W-1:0] pc;
        logic                 pc_ok;
    } slot_s;

    slot_s s_d, s_q;

    always_comb begin
        slot_free = !s_q.valid || out_ready;
        s_d       = s_q;
        if (s_q.valid && out_ready) s_d.valid = 1'b0;
        if (emit_valid) begin
            s_d.valid   = 1'b1;
            s_d.kind    = emit_kind;
            s_d.flags   = emit_flags;
            s_d.payload = emit_payload;
            s_d.pc      = emit_pc;
            s_d.pc_ok   = emit_pc_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= KIND_DATA;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid   = s_q.valid;
    assign out_kind    = s_q.kind;
    assign out_flags   = s_q.flags;
    assign out_payload = s_q.payload;
    assign out_pc      = s_q.pc;
    assign out_pc_ok   = s_q.pc_ok;

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |-> (!s_q.valid || out_ready)); // R10
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_kind, out_flags, out_payload, out_pc, out_pc_ok}))); // R9
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 2'b11)); // R2
    AST_ZERO_PC_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_pc_ok) |-> (out_pc == '0)); // R11
endmodule

// File: rtl/trace_pc_rebuild.sv
module trace_pc_rebuild
    import trc_pkg::*;
#(
    parameter int                   PAYLOAD_W  = 32,
    parameter logic [PAYLOAD_W-1:0] IRQ_VECTOR = 'h10,
    localparam int                  REC_W      = PAYLOAD_W + FLAG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [REC_W-1:0]     in_rec,
    output logic                 lk_req_valid,
    input  logic                 lk_req_ready,
    output logic [PAYLOAD_W-1:0] lk_req_pc,
    input  logic                 lk_rsp_valid,
    input  logic                 lk_rsp_hit,
    input  logic [1:0]           lk_rsp_opc,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [1:0]           out_kind,
    output logic [FLAG_W-1:0]    out_flags,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic [PAYLOAD_W-1:0] out_pc,
    output logic                 out_pc_ok
);
    trc_kind_e            dec_kind;
    logic                 dec_irq, dec_addr, dec_branch;
    logic [FLAG_W-1:0]    dec_flags;
    logic [PAYLOAD_W-1:0] dec_payload;
    logic                 slot_free;
    logic                 emit_valid, emit_pc_ok;
    trc_kind_e            emit_kind;
    logic [FLAG_W-1:0]    emit_flags;
    logic [PAYLOAD_W-1:0] emit_payload, emit_pc;

    trc_flag_decode #(.PAYLOAD_W(PAYLOAD_W)) u_dec (
        .rec       (in_rec),
        .kind      (dec_kind),
        .irq       (dec_irq),
        .is_addr   (dec_addr),
        .is_branch (dec_branch),
        .flags     (dec_flags),
        .payload   (dec_payload)
    );

    trc_pc_track #(.PAYLOAD_W(PAYLOAD_W), .IRQ_VECTOR(IRQ_VECTOR)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .dec_kind     (dec_kind),
        .dec_irq      (dec_irq),
        .dec_addr     (dec_addr),
        .dec_branch   (dec_branch),
        .dec_flags    (dec_flags),
        .dec_payload  (dec_payload),
        .slot_free    (slot_free),
        .lk_req_valid (lk_req_valid),
        .lk_req_ready (lk_req_ready),
        .lk_req_pc    (lk_req_pc),
        .lk_rsp_valid (lk_rsp_valid),
        .lk_rsp_hit   (lk_rsp_hit),
        .lk_rsp_opc   (lk_rsp_opc),
        .emit_valid   (emit_valid),
        .emit_kind    (emit_kind),
        .emit_flags   (emit_flags),
        .emit_payload (emit_payload),
        .emit_pc      (emit_pc),
        .emit_pc_ok   (emit_pc_ok)
    );

    trc_out_stage #(.PAYLOAD_W(PAYLOAD_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .emit_valid   (emit_valid),
        .emit_kind    (emit_kind),
        .emit_flags   (emit_flags),
        .emit_payload (emit_payload),
        .emit_pc      (emit_pc),
        .emit_pc_ok   (emit_pc_ok),
        .slot_free    (slot_free),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_kind     (out_kind),
        .out_flags    (out_flags),
        .out_payload  (out_payload),
        .out_pc       (out_pc),
        .out_pc_ok    (out_pc_ok)
    );
endmodule

// File: tb/sim_trace_pc_rebuild.sv
module sim_trace_pc_rebuild;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [35:0] in_rec;
    logic        lk_req_valid;
    logic        lk_req_ready;
    logic [31:0] lk_req_pc;
    logic        lk_rsp_valid;
    logic        lk_rsp_hit;
    logic [1:0]  lk_rsp_opc;
    logic        out_valid;
    logic        out_ready;
    logic [1:0]  out_kind;
    logic [3:0]  out_flags;
    logic [31:0] out_payload;
    logic [31:0] out_pc;
    logic        out_pc_ok;

    always #5 clk = ~clk;

    trace_pc_rebuild u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_rec(in_rec),
        .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready), .lk_req_pc(lk_req_pc),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit), .lk_rsp_opc(lk_rsp_opc),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_flags(out_flags),
        .out_payload(out_payload), .out_pc(out_pc), .out_pc_ok(out_pc_ok)
    );

    typedef struct {
        logic [1:0]  kind;
        logic [3:0]  flags;
        logic [31:0] payload;
        logic [31:0] pc;
        logic        ok;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          errors = 0;
    int          exp_req = 0;
    int          got_req = 0;
    bit          bp_mode = 1'b0;
    bit          finished = 1'b0;
    logic [31:0] m_pc = '0;
    bit          m_ok = 1'b0;
    bit          m_last_irq = 1'b0;

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void tbl(input logic [31:0] pc, output logic hit, output logic [1:0] opc);
        hit = (pc >= 32'h10 && pc < 32'h80) || (pc >= 32'h1000 && pc < 32'h1100);
        opc = (pc[3:1] == 3'b010 || pc[3:1] == 3'b111) ? 2'b01 : 2'b11;
    endfunction

    function automatic logic [35:0] mk(input bit irq, input bit adr, input bit br, input logic [31:0] p);
        return {irq, 1'b0, adr, br, p};
    endfunction

    task automatic send(input logic [35:0] rec, input string tag);
        exp_t e;
        logic hit;
        logic [1:0] opc;
        bit acc;
        bit irq = rec[35];
        bit adr = rec[33];
        bit br  = rec[32];
        e.kind    = br ? 2'b01 : (adr ? 2'b10 : 2'b00);
        e.flags   = rec[35:32];
        e.payload = rec[31:0];
        e.tag     = tag;
        if (irq && !m_last_irq) begin
            m_pc = 32'h10;
            m_ok = 1'b1;
        end
        m_last_irq = irq;
        e.pc = '0;
        e.ok = 1'b0;
        if (m_ok) begin
            exp_req++;
            tbl(m_pc, hit, opc);
            if (hit) begin
                e.pc = m_pc;
                e.ok = 1'b1;
                if (!adr) m_pc = m_pc + ((opc == 2'b11) ? 32'd4 : 32'd2);
            end else begin
                m_ok = 1'b0;
            end
        end
        if (br) begin
            m_pc = rec[31:0];
            m_ok = 1'b1;
        end
        sbq.push_back(e);
        @(negedge clk);
        in_valid = 1'b1;
        in_rec   = rec;
        forever begin
            #2;
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid && out_ready) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R10", "output with empty queue", 64'(out_payload), 64'h0);
                end else begin
                    e = sbq.pop_front();
                    check(out_kind == e.kind, "R2", "kind", 64'(out_kind), 64'(e.kind));
                    check(out_flags == e.flags && out_payload == e.payload, "R10", "flags/payload",
                          {28'h0, out_flags, out_payload}, {28'h0, e.flags, e.payload});
                    check(out_pc_ok == e.ok && out_pc == e.pc, e.tag, "pc_ok/pc",
                          {31'h0, out_pc_ok, out_pc}, {31'h0, e.ok, e.pc});
                end
            end
        end
    end

    // lookup port model
    initial begin
        logic [31:0] pend_pc;
        logic        h;
        logic [1:0]  o;
        bit          pend = 1'b0;
        int          rcnt = 0;
        lk_req_ready = 1'b0;
        lk_rsp_valid = 1'b0;
        lk_rsp_hit   = 1'b0;
        lk_rsp_opc   = 2'b00;
        forever begin
            @(negedge clk);
            lk_rsp_valid = 1'b0;
            if (pend) begin
                tbl(pend_pc, h, o);
                lk_rsp_valid = 1'b1;
                lk_rsp_hit   = h;
                lk_rsp_opc   = o;
                pend         = 1'b0;
                lk_req_ready = 1'b0;
            end else if (rst_n && lk_req_valid) begin
                check(in_ready == 1'b0, "R9", "in_ready during lookup", 64'(in_ready), 64'h0);
                rcnt++;
                lk_req_ready = (rcnt % 3 != 1);
                if (lk_req_ready) begin
                    pend    = 1'b1;
                    pend_pc = lk_req_pc;
                    got_req++;
                end
            end else begin
                lk_req_ready = 1'b0;
            end
        end
    end

    // downstream readiness
    initial begin
        int c = 0;
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            c++;
            out_ready = bp_mode ? (c % 3 == 0) : 1'b1;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_rec   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
        check(lk_req_valid == 1'b0, "R1", "lk_req_valid after reset", 64'(lk_req_valid), 64'h0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);

        // untracked start
        send(mk(0, 0, 0, 32'hAAAA0001), "R1");
        send(mk(0, 1, 0, 32'h00008000), "R1");
        check(got_req == 0, "R1", "lookups before tracking", 64'(got_req), 64'h0);
        // both markers: branch wins, target 0x20
        send(mk(0, 1, 1, 32'h00000020), "R2");
        for (int i = 0; i < 5; i++) send(mk(0, 0, 0, 32'h100 + i), "R4");
        // address then data of one access
        send(mk(0, 1, 0, 32'h00009000), "R5");
        send(mk(0, 0, 0, 32'h00000111), "R5");
        send(mk(0, 1, 0, 32'h00009004), "R5");
        send(mk(0, 1, 0, 32'h00009008), "R5");
        // tracked branch
        send(mk(0, 0, 1, 32'h00001000), "R3");
        for (int i = 0; i < 3; i++) send(mk(0, 0, 0, 32'h200 + i), "R4");
        // interrupt entry, stay, leave, re-enter
        send(mk(1, 0, 0, 32'h00000300), "R6");
        send(mk(1, 0, 0, 32'h00000301), "R6");
        send(mk(1, 1, 0, 32'h00000302), "R6");
        send(mk(1, 0, 0, 32'h00000303), "R6");
        send(mk(0, 0, 0, 32'h00000304), "R6");
        send(mk(1, 0, 0, 32'h00000305), "R6");
        // branch to unknown code: miss then untracked
        send(mk(0, 0, 1, 32'h00005000), "R7");
        send(mk(0, 0, 0, 32'h00000400), "R7");
        send(mk(0, 0, 0, 32'h00000401), "R7");
        send(mk(0, 1, 0, 32'h00000402), "R7");
        check(got_req == exp_req, "R7", "no lookups while untracked", 64'(got_req), 64'(exp_req));
        // interrupt entry regains tracking
        send(mk(1, 0, 0, 32'h00000500), "R6");
        // branch whose own lookup misses still retargets
        send(mk(1, 0, 1, 32'h00005000), "R7");
        send(mk(1, 0, 1, 32'h00001008), "R3");
        send(mk(0, 0, 0, 32'h00000600), "R3");
        // back-pressured stream
        bp_mode = 1'b1;
        for (int i = 0; i < 24; i++) begin
            case (i % 6)
                0: send(mk(0, 0, 1, 32'h1000 + 32'(i * 8)), "R9");
                1: send(mk(0, 1, 0, 32'h00009100 + i), "R9");
                5: send(mk(1, 0, 0, 32'h00000700 + i), "R9");
                default: send(mk(0, 0, 0, 32'h00000700 + i), "R9");
            endcase
        end
        for (int i = 0; i < 400 && sbq.size() != 0; i++) @(negedge clk);
        bp_mode = 1'b0;
        check(sbq.size() == 0, "R10", "outputs outstanding", 64'(sbq.size()), 64'h0);
        check(got_req == exp_req, "R8", "lookup count", 64'(got_req), 64'(exp_req));
        repeat (3) @(negedge clk);
        summary();
    end
endmodule